// File: doc/BRIEF.md
# Byte-Serial Two-Byte Accumulator ALU

This block performs 16-bit word operations with an 8-bit datapath. A word operation takes two consecutive clock cycles. The low byte is handled first and the high byte second. The accumulator is made of two byte registers, a high half and a low half. On every active byte cycle the adder result enters the high half while the old high half drops into the low half. After the second cycle the full result therefore sits in the right order.

All functions share one byte-wide adder. The two adder operands are gated per function:

- The first operand is the accumulator low half, that half shifted right by one, or zero.
- The second operand is the data byte masked either by all-ones or by the inverse of the low half, or it is the low half itself.

Because of this gating, the bit-clear and bit-set functions pass through the adder without ever producing a carry. The word carry is kept in a flag that only the add and shift-left functions change.

A controller issues a one-cycle start strobe together with the function code and the low data byte. On the next cycle it drives the high data byte. The done output then marks the cycle in which the finished word is valid.

Top module: `byteserial_alu`

## Requirements
- R1: After reset the accumulator output is 0, the carry output is 0 and done is 0.
- R2: Function code 0 (load) leaves the accumulator equal to the 16-bit data word, formed from the low byte on the start cycle and the high byte on the following cycle. The carry output does not change.
- R3: Function code 1 (add) leaves the accumulator equal to the old accumulator plus the data word, modulo 2^16. The carry output becomes bit 16 of that sum, using the low-byte carry as carry-in to the high byte.
- R4: Function code 2 (bit clear) leaves the accumulator equal to data AND NOT old accumulator. The carry output does not change.
- R5: Function code 3 (bit set) leaves the accumulator equal to data OR old accumulator, and the adder never produces a carry during it. The carry output does not change.
- R6: Function code 4 (shift right) leaves the accumulator equal to (old accumulator shifted right by one, with 0 entering bit 15) plus the data word, modulo 2^16. Bit 8 of the old word enters bit 7. The carry output does not change.
- R7: Function code 5 (shift left) leaves the accumulator equal to the old accumulator shifted left by one with 0 entering bit 0. The carry output becomes old bit 15, and the data bus is ignored.
- R8: A start strobe accepted at an edge processes the low byte at that edge and the high byte at the next edge. After the first edge the accumulator reads {new low byte, old high byte}. Done is high for exactly the one cycle after the second edge.
- R9: A start strobe presented during the high-byte cycle is ignored: the running operation finishes unchanged and no new operation begins.
- R10: Reserved function codes 6 and 7 behave as load (code 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Starts a word operation; the low data byte is taken on this cycle |
| func_i | input | 3 | Function code, sampled with start_i |
| data_i | input | BYTE_W | Data bus byte: low byte on the start cycle, high byte on the next |
| acc_o | output | 2*BYTE_W | Accumulator, {high half, low half} |
| carry_o | output | 1 | Carry flag from the last add or shift-left |
| done_o | output | 1 | High for one cycle when the word result is valid |

## Verification
The bench builds the block with the default byte width of 8, so the word is 16 bits and exhaustive corner values such as 0xFFFF + 0x0001 can be chosen by hand. At this width the carry link from the low byte into the high byte is visible, as are the bit shifted from the high into the low half on a right shift and the carry out of bit 15. The bench also checks the half-rotated accumulator after the first byte cycle, a start strobe raised during the second cycle, and the reserved function codes.

// File: rtl/bsalu_pkg.sv
package bsalu_pkg;

  typedef enum logic [2:0] {
    FN_LOAD = 3'd0,
    FN_ADD  = 3'd1,
    FN_BIC  = 3'd2,
    FN_BIS  = 3'd3,
    FN_SHR  = 3'd4,
    FN_SHL  = 3'd5
  } alu_fn_e;

  // Functions whose word carry is written into the visible flag.
  function automatic logic fn_sets_carry(input alu_fn_e fn);
    return (fn == FN_ADD) || (fn == FN_SHL);
  endfunction

endpackage

// File: rtl/bsalu_operand_gate.sv
module bsalu_operand_gate
  import bsalu_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  alu_fn_e           fn,
  input  logic [BYTE_W-1:0] acc_lo,
  input  logic              shift_in,
  input  logic [BYTE_W-1:0] data,
  output logic [BYTE_W-1:0] opa,
  output logic [BYTE_W-1:0] opb
);

  logic [BYTE_W-1:0] ones;
  logic [BYTE_W-1:0] inv_mask;

  always_comb begin
    ones     = '1;
    inv_mask = ~acc_lo;
    unique case (fn)
      FN_ADD: begin
        opa = acc_lo;
        opb = data & ones;
      end
      FN_BIC: begin
        opa = '0;
        opb = data & inv_mask;
      end
      FN_BIS: begin
        opa = acc_lo;
        opb = data & inv_mask;
      end
      FN_SHR: begin
        opa = {shift_in, acc_lo[BYTE_W-1:1]};
        opb = data & ones;
      end
      FN_SHL: begin
        opa = acc_lo;
        opb = acc_lo;
      end
      default: begin
        opa = '0;
        opb = data & ones;
      end
    endcase
  end

endmodule

// File: rtl/bsalu_byte_adder.sv
module bsalu_byte_adder #(
  parameter int BYTE_W = 8
) (
  input  logic [BYTE_W-1:0] a,
  input  logic [BYTE_W-1:0] b,
  input  logic              cin,
  output logic [BYTE_W-1:0] sum,
  output logic              cout
);

  localparam int SUM_W = BYTE_W + 1;

  logic [SUM_W-1:0] total;

  always_comb begin
    total = {1'b0, a} + {1'b0, b} + {{BYTE_W{1'b0}}, cin};
    sum   = total[BYTE_W-1:0];
    cout  = total[SUM_W-1];
  end

endmodule

// File: rtl/bsalu_sequencer.sv
module bsalu_sequencer
  import bsalu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [2:0] fn_in,
  output logic       phase_hi,
  output alu_fn_e    fn_held,
  output logic       done
);

  logic    phase_n;
  logic    done_n;
  alu_fn_e fn_n;
  logic    accept;

  always_comb begin
    accept  = start && !phase_hi;
    phase_n = accept;
    done_n  = phase_hi;
    fn_n    = accept ? alu_fn_e'(fn_in) : fn_held;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_hi <= 1'b0;
      done     <= 1'b0;
      fn_held  <= FN_LOAD;
    end else begin
      phase_hi <= phase_n;
      done     <= done_n;
      fn_held  <= fn_n;
    end
  end

  // R8: the high-byte cycle lasts exactly one cycle
  assert_one_high_beat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    phase_hi |=> !phase_hi);

  // R8: done only follows a high-byte cycle
  assert_done_after_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(phase_hi));

  // R9: a start during the high-byte cycle does not open a new operation
  assert_busy_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_hi && start) |=> (done && !phase_hi));

endmodule

// File: rtl/byteserial_alu.sv
module byteserial_alu
  import bsalu_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [2:0]          func_i,
  input  logic [BYTE_W-1:0]   data_i,
  output logic [2*BYTE_W-1:0] acc_o,
  output logic                carry_o,
  output logic                done_o
);

  localparam int SYNC_STAGES = 2;

  // reset: asserted asynchronously, released on the clock
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_core_n = rst_pipe[SYNC_STAGES-1];

  // sequencing
  logic    phase_hi;
  alu_fn_e fn_held;
  logic    done_q;

  bsalu_sequencer i_seq (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .start    (start_i),
    .fn_in    (func_i),
    .phase_hi (phase_hi),
    .fn_held  (fn_held),
    .done     (done_q)
  );

  // datapath state
  logic [BYTE_W-1:0] acc_hi, acc_lo;
  logic              carry_link;
  logic              carry_flag;

  logic [BYTE_W-1:0] acc_hi_n, acc_lo_n;
  logic              carry_link_n, carry_flag_n;

  alu_fn_e           fn_act;
  logic              step;
  logic              shift_in;
  logic              cin;
  logic [BYTE_W-1:0] opa, opb, sum;
  logic              cout;

  always_comb begin
    step     = phase_hi || start_i;
    fn_act   = phase_hi ? fn_held : alu_fn_e'(func_i);
    shift_in = phase_hi ? 1'b0 : acc_hi[0];
    cin      = phase_hi ? carry_link : 1'b0;
  end

  bsalu_operand_gate #(.BYTE_W(BYTE_W)) i_gate (
    .fn       (fn_act),
    .acc_lo   (acc_lo),
    .shift_in (shift_in),
    .data     (data_i),
    .opa      (opa),
    .opb      (opb)
  );

  bsalu_byte_adder #(.BYTE_W(BYTE_W)) i_add (
    .a    (opa),
    .b    (opb),
    .cin  (cin),
    .sum  (sum),
    .cout (cout)
  );

  always_comb begin
    acc_hi_n     = acc_hi;
    acc_lo_n     = acc_lo;
    carry_link_n = carry_link;
    carry_flag_n = carry_flag;
    if (step) begin
      acc_hi_n = sum;
      acc_lo_n = acc_hi;
    end
    if (step && !phase_hi) carry_link_n = cout;
    if (phase_hi && fn_sets_carry(fn_held)) carry_flag_n = cout;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      acc_hi     <= '0;
      acc_lo     <= '0;
      carry_link <= 1'b0;
      carry_flag <= 1'b0;
    end else begin
      acc_hi     <= acc_hi_n;
      acc_lo     <= acc_lo_n;
      carry_link <= carry_link_n;
      carry_flag <= carry_flag_n;
    end
  end

  assign acc_o   = {acc_hi, acc_lo};
  assign carry_o = carry_flag;
  assign done_o  = done_q;

  // R8: every byte cycle moves the high half into the low half
  assert_half_rotate_R8: assert property (@(posedge clk) disable iff (!rst_core_n)
    step |=> (acc_lo == $past(acc_hi)));

  // R5: the bit-set path never produces a carry out of the adder
  assert_bis_no_carry_R5: assert property (@(posedge clk) disable iff (!rst_core_n)
    (step && fn_act == FN_BIS) |-> !cout);

  // R4: the carry flag holds unless an add or shift-left finishes its high byte
  assert_carry_hold_R4: assert property (@(posedge clk) disable iff (!rst_core_n)
    !(phase_hi && fn_sets_carry(fn_held)) |=> $stable(carry_o));

  // R1: idle without a start keeps the accumulator
  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!step) |=> $stable(acc_o));

endmodule

// File: tb/test_byteserial_alu.sv
module test_byteserial_alu;
  localparam int BYTE_W = 8;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [2:0]  func_i;
  logic [7:0]  data_i;
  logic [15:0] acc_o;
  logic        carry_o;
  logic        done_o;

  int n_checks = 0;
  int n_fails  = 0;

  logic [15:0] m_acc;
  logic        m_carry;

  byteserial_alu #(.BYTE_W(BYTE_W)) i_byteserial_alu (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .func_i  (func_i),
    .data_i  (data_i),
    .acc_o   (acc_o),
    .carry_o (carry_o),
    .done_o  (done_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // runs one word operation and checks intermediate, final and done timing
  task automatic do_op(input string req, input logic [2:0] fn, input logic [15:0] d);
    logic [15:0] exp;
    logic        exp_c;
    logic [16:0] wide;
    exp_c = m_carry;
    case (fn)
      3'd1: begin wide = {1'b0, m_acc} + {1'b0, d}; exp = wide[15:0]; exp_c = wide[16]; end
      3'd2: exp = d & ~m_acc;
      3'd3: exp = d | m_acc;
      3'd4: exp = (m_acc >> 1) + d;
      3'd5: begin exp = m_acc << 1; exp_c = m_acc[15]; end
      default: exp = d;
    endcase
    @(negedge clk);
    start_i = 1'b1; func_i = fn; data_i = d[7:0];
    @(negedge clk);
    chk({req, " R8 half-rotated"}, acc_o, {exp[7:0], m_acc[15:8]});
    chk({req, " R8 no early done"}, done_o, 0);
    start_i = 1'b0; func_i = 3'd7; data_i = d[15:8];
    @(negedge clk);
    chk({req, " done"}, done_o, 1);
    chk({req, " acc"}, acc_o, exp);
    chk({req, " carry"}, carry_o, exp_c);
    data_i = 8'hA5;
    @(negedge clk);
    chk({req, " R8 done one cycle"}, done_o, 0);
    chk({req, " R8 acc held"}, acc_o, exp);
    m_acc = exp; m_carry = exp_c;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start_i = 1'b0; func_i = 3'd0; data_i = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 acc", acc_o, 0);
    chk("R1 carry", carry_o, 0);
    chk("R1 done", done_o, 0);
    m_acc = 16'h0000; m_carry = 1'b0;
  endtask

  task automatic t_load();
    do_op("R2 load", 3'd0, 16'h1234);
    do_op("R2 load ones", 3'd0, 16'hFFFF);
  endtask

  task automatic t_add();
    do_op("R3 add wrap", 3'd1, 16'h0001);        // FFFF+1 -> 0, carry 1
    do_op("R2 load after add", 3'd0, 16'h00FF);  // carry held at 1
    do_op("R3 add low carry", 3'd1, 16'h0001);   // low carry into high byte
    do_op("R3 add plain", 3'd1, 16'h1234);
  endtask

  task automatic t_bic();
    do_op("R2 load", 3'd0, 16'hF0F0);
    do_op("R4 bic", 3'd2, 16'hFF0F);
  endtask

  task automatic t_bis();
    do_op("R2 load", 3'd0, 16'h8421);
    do_op("R5 bis", 3'd3, 16'h1248);
    do_op("R5 bis overlap", 3'd3, 16'hFFFF);
  endtask

  task automatic t_shr();
    do_op("R2 load", 3'd0, 16'h0181);
    do_op("R6 shr", 3'd4, 16'h0000);             // bit 8 into bit 7
    do_op("R6 shr add data", 3'd4, 16'h00C0);
  endtask

  task automatic t_shl();
    do_op("R2 load", 3'd0, 16'h8080);
    do_op("R7 shl data ignored", 3'd5, 16'h5A5A); // carry 1, cross-byte bit
    do_op("R7 shl no carry", 3'd5, 16'h0000);
  endtask

  task automatic t_busy();
    logic [15:0] exp;
    do_op("R2 load", 3'd0, 16'h0F0F);
    exp = 16'h0F0F + 16'h0102;
    @(negedge clk);
    start_i = 1'b1; func_i = 3'd1; data_i = 8'h02;
    @(negedge clk);
    func_i = 3'd0; data_i = 8'h01;  // start kept high in high-byte cycle
    @(negedge clk);
    start_i = 1'b0; data_i = 8'h77;
    chk("R9 done", done_o, 1);
    chk("R9 acc", acc_o, exp);
    @(negedge clk);
    chk("R9 no second op done", done_o, 0);
    chk("R9 no second op acc", acc_o, exp);
    m_acc = exp; m_carry = 1'b0;
    chk("R9 carry", carry_o, 0);
  endtask

  task automatic t_reserved();
    do_op("R10 code 6", 3'd6, 16'hBEEF);
    do_op("R10 code 7", 3'd7, 16'h1357);
  endtask

  initial begin
    t_reset();
    t_load();
    t_add();
    t_bic();
    t_bis();
    t_shr();
    t_shl();
    t_busy();
    t_reserved();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule